// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a two-level logic array whose connections are held in configuration rows. Thirty-nine logic signals enter the array. Each signal is offered to the AND plane as itself and as its inverse, which gives 78 literals. Each row of the AND plane selects any subset of these literals and forms a product term. Sixty-four of the product terms are shared. They feed an OR plane of 36 rows, and each of those rows selects any subset of the shared terms, from none up to all 64, to form a sum term. One further product term serves as a global reset line, and ten more serve as output-enable lines. These eleven dedicated terms never reach the OR plane.

Sum term j (j from 0 to 17) is the data term of output cell j. Sum term 18+j is the enable or clock term of the same cell. Term evaluation is purely combinational from the stored configuration.

The only state in the block is the configuration store. It is written one row per clock through an address/data port, and it is read back through the same port with one cycle of latency. The store also holds a 72-bit user signature and a protection flag. Once the flag is set, AND-plane rows read back as zero and all writes are refused, until a bulk erase clears the whole store. The signature stays readable at all times.

Top module: `pla_array`

## Requirements
- R1: Product term r is the AND of every literal whose bit is set in AND row r (address r, 0 to 74). Bit 2k of the row selects signal k in true form, and bit 2k+1 selects signal k in complement form.
- R2: A product term whose row has no bit set evaluates to 1. A sum term whose row has no bit set evaluates to 0.
- R3: Sum term s is the OR of the shared product terms 0 to 63 whose bits are set in OR row s (address 75+s, bits 0 to 63). Sum s below 18 drives data_term[s], and sum 18+j drives en_term[j].
- R4: Product term 64 drives reset_term. Product terms 65 to 74 drive oe_term[0] to oe_term[9]. None of these eleven terms enters the OR plane.
- R5: A write (cfg_we) stores cfg_wdata into the addressed row at the clock edge. A read (cfg_re) presents the addressed row on cfg_rdata at the next edge, zero-extended. Address 111 holds the signature in bits 71:0. Address 112 reads the protection flag in bit 0. Any other address reads zero.
- R6: Writing address 112 with bit 0 set sets the protection flag. While the flag is set, reads of AND rows (addresses 0 to 74) return zero, and reads of OR rows and of the signature return their contents.
- R7: While the protection flag is set, every write is ignored and the outputs keep their behaviour.
- R8: A cfg_erase pulse clears every AND row, every OR row, the signature and the protection flag at one clock edge. It takes priority over a write in the same cycle.
- R9: After reset, the whole store is zero. Therefore reset_term and every oe_term bit are 1, every data_term and en_term bit is 0, and cfg_rdata is zero.
- R10: A row write changes the term outputs from the edge that stores it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 39 | Array signals: inputs, pin inputs, feedbacks and input clock |
| cfg_we | input | 1 | Row write strobe |
| cfg_re | input | 1 | Row read strobe |
| cfg_erase | input | 1 | Bulk erase of the whole store |
| cfg_addr | input | 7 | Row address |
| cfg_wdata | input | 78 | Row write data |
| cfg_rdata | output | 78 | Registered readback data |
| data_term | output | 18 | Data sum term per output cell |
| en_term | output | 18 | Enable/clock sum term per output cell |
| reset_term | output | 1 | Global reset product term |
| oe_term | output | 10 | Output-enable product terms |

## Verification
The term outputs are combinational. They are due in the same cycle that sig_in changes, and in the cycle that follows the edge storing a row. The bench drives each change on a falling edge and compares the terms shortly after that edge, before the next rising edge.

Readback data is due one rising edge after cfg_re. The driver queues the expected row when it raises cfg_re. A monitor sees the read at that edge and pops and compares the row on the following falling edge, so each comparison is tied to the edge that produced the data.

Protection and erase are checked both through readback and through the term outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned PLA_N_SIG    = 39;
  localparam int unsigned PLA_N_SHARED = 64;
  localparam int unsigned PLA_N_OE     = 10;
  localparam int unsigned PLA_N_CELL   = 18;
  localparam int unsigned PLA_SIG_W    = 72;

  typedef enum logic [2:0] {
    RG_AND,
    RG_OR,
    RG_SIG,
    RG_LOCK,
    RG_NONE
  } cfg_rgn_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int unsigned N_PT  = 75,
  parameter int unsigned N_SUM = 36,
  parameter int unsigned AND_W = 78,
  parameter int unsigned OR_W  = 64,
  parameter int unsigned SIG_W = 72,
  parameter int unsigned AW    = 7,
  localparam int unsigned DW       = AND_W,
  localparam int unsigned OR_BASE  = N_PT,
  localparam int unsigned SIG_ADDR = N_PT + N_SUM,
  localparam int unsigned LCK_ADDR = SIG_ADDR + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_re,
  input  logic                            cfg_erase,
  input  logic [AW-1:0]                   cfg_addr,
  input  logic [DW-1:0]                   cfg_wdata,
  output logic [DW-1:0]                   cfg_rdata,
  output logic [N_PT-1:0][AND_W-1:0]      and_cfg,
  output logic [N_SUM-1:0][OR_W-1:0]      or_cfg
);
  logic [N_PT-1:0][AND_W-1:0] and_q;
  logic [N_SUM-1:0][OR_W-1:0] or_q;
  logic [SIG_W-1:0]           sig_q;
  logic                       lock_q;
  logic                       lock_d;
  logic                       wr_ok;
  cfg_rgn_e                   rgn;
  logic [DW-1:0]              rd_d;
  logic [DW-1:0]              rd_and;
  logic [DW-1:0]              rd_or;

  // region decode
  always_comb begin
    if (cfg_addr < AW'(OR_BASE))        rgn = RG_AND;
    else if (cfg_addr < AW'(SIG_ADDR))  rgn = RG_OR;
    else if (cfg_addr == AW'(SIG_ADDR)) rgn = RG_SIG;
    else if (cfg_addr == AW'(LCK_ADDR)) rgn = RG_LOCK;
    else                                rgn = RG_NONE;
  end

  assign wr_ok = cfg_we && !lock_q && !cfg_erase;

  // AND-plane rows
  for (genvar r = 0; r < N_PT; r++) begin : g_and_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        and_q[r] <= '0;
      else if (cfg_erase)
        and_q[r] <= '0;
      else if (wr_ok && (cfg_addr == AW'(r)))
        and_q[r] <= cfg_wdata[AND_W-1:0];
    end
  end

  // OR-plane rows
  for (genvar s = 0; s < N_SUM; s++) begin : g_or_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        or_q[s] <= '0;
      else if (cfg_erase)
        or_q[s] <= '0;
      else if (wr_ok && (cfg_addr == AW'(OR_BASE + s)))
        or_q[s] <= cfg_wdata[OR_W-1:0];
    end
  end

  // signature row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sig_q <= '0;
    else if (cfg_erase)
      sig_q <= '0;
    else if (wr_ok && (rgn == RG_SIG))
      sig_q <= cfg_wdata[SIG_W-1:0];
  end

  // protection flag: set by write, cleared only by erase or reset
  always_comb begin
    lock_d = lock_q;
    if (cfg_erase)
      lock_d = 1'b0;
    else if (wr_ok && (rgn == RG_LOCK) && cfg_wdata[0])
      lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // readback selection
  always_comb begin
    rd_and = '0;
    for (int r = 0; r < N_PT; r++)
      if (cfg_addr == AW'(r)) rd_and = DW'(and_q[r]);
    rd_or = '0;
    for (int s = 0; s < N_SUM; s++)
      if (cfg_addr == AW'(OR_BASE + s)) rd_or = DW'(or_q[s]);
  end

  always_comb begin
    unique case (rgn)
      RG_AND:  rd_d = lock_q ? '0 : rd_and;
      RG_OR:   rd_d = rd_or;
      RG_SIG:  rd_d = DW'(sig_q);
      RG_LOCK: rd_d = DW'(lock_q);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_rdata <= '0;
    else if (cfg_re)
      cfg_rdata <= rd_d;
  end

  assign and_cfg = and_q;
  assign or_cfg  = or_q;

  // R6: protected AND rows never leak
  a_r6_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && lock_q && (cfg_addr < AW'(OR_BASE))) |=> (cfg_rdata == '0))
    else $error("R6 locked AND row leaked");

  // R7: protected store is frozen unless erased
  a_r7_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cfg_erase) |=> (lock_q && $stable(and_q) && $stable(or_q) && $stable(sig_q)))
    else $error("R7 store changed while locked");

  // R8: erase empties everything in one edge
  a_r8_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (!lock_q && (and_q == '0) && (or_q == '0) && (sig_q == '0)))
    else $error("R8 erase incomplete");

  // R5: signature readback carries the stored value
  a_r5_sig_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && (cfg_addr == AW'(SIG_ADDR))) |=> (cfg_rdata == DW'($past(sig_q))))
    else $error("R5 signature readback wrong");
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_SIG = 39,
  parameter int unsigned N_PT  = 75,
  localparam int unsigned LW   = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]          sig_in,
  input  logic [N_PT-1:0][LW-1:0]   cfg,
  output logic [N_PT-1:0]           pt
);
  logic [LW-1:0] lit;

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   = sig_in[k];
    assign lit[2*k+1] = ~sig_in[k];
  end

  // an unconnected literal is forced to 1, so an empty row yields 1
  for (genvar r = 0; r < N_PT; r++) begin : g_pt
    assign pt[r] = &(~cfg[r] | lit);
  end

  // R1: a row selecting both forms of a signal can never be true
  always_comb begin
    for (int r = 0; r < N_PT; r++)
      for (int k = 0; k < N_SIG; k++)
        if (cfg[r][2*k] && cfg[r][2*k+1])
          a_r1_contradiction: assert (pt[r] == 1'b0)
            else $error("R1 contradictory row true");
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_IN  = 64,
  parameter int unsigned N_SUM = 36
) (
  input  logic [N_IN-1:0]             pt_in,
  input  logic [N_SUM-1:0][N_IN-1:0]  cfg,
  output logic [N_SUM-1:0]            sum
);
  for (genvar s = 0; s < N_SUM; s++) begin : g_sum
    assign sum[s] = |(cfg[s] & pt_in);
  end

  // R2: an empty OR row stays low
  always_comb begin
    for (int s = 0; s < N_SUM; s++)
      if (cfg[s] == '0)
        a_r2_empty_sum: assert (sum[s] == 1'b0)
          else $error("R2 empty sum term high");
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_SIG    = PLA_N_SIG,
  parameter int unsigned N_SHARED = PLA_N_SHARED,
  parameter int unsigned N_OE     = PLA_N_OE,
  parameter int unsigned N_CELL   = PLA_N_CELL,
  parameter int unsigned SIG_W    = PLA_SIG_W,
  localparam int unsigned N_PT    = N_SHARED + 1 + N_OE,
  localparam int unsigned N_SUM   = 2 * N_CELL,
  localparam int unsigned AND_W   = 2 * N_SIG,
  localparam int unsigned AW      = $clog2(N_PT + N_SUM + 2),
  localparam int unsigned RST_IDX = N_SHARED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SIG-1:0]  sig_in,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic              cfg_erase,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [AND_W-1:0]  cfg_wdata,
  output logic [AND_W-1:0]  cfg_rdata,
  output logic [N_CELL-1:0] data_term,
  output logic [N_CELL-1:0] en_term,
  output logic              reset_term,
  output logic [N_OE-1:0]   oe_term
);
  logic [N_PT-1:0][AND_W-1:0]     and_cfg;
  logic [N_SUM-1:0][N_SHARED-1:0] or_cfg;
  logic [N_PT-1:0]                pt;
  logic [N_SUM-1:0]               sum;

  pla_cfg_store #(
    .N_PT (N_PT),
    .N_SUM(N_SUM),
    .AND_W(AND_W),
    .OR_W (N_SHARED),
    .SIG_W(SIG_W),
    .AW   (AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_re   (cfg_re),
    .cfg_erase(cfg_erase),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .and_cfg  (and_cfg),
    .or_cfg   (or_cfg)
  );

  pla_and_plane #(
    .N_SIG(N_SIG),
    .N_PT (N_PT)
  ) u_and (
    .sig_in(sig_in),
    .cfg   (and_cfg),
    .pt    (pt)
  );

  pla_or_plane #(
    .N_IN (N_SHARED),
    .N_SUM(N_SUM)
  ) u_or (
    .pt_in(pt[N_SHARED-1:0]),
    .cfg  (or_cfg),
    .sum  (sum)
  );

  assign data_term  = sum[N_CELL-1:0];
  assign en_term    = sum[N_SUM-1:N_CELL];
  assign reset_term = pt[RST_IDX];
  assign oe_term    = pt[N_PT-1:RST_IDX+1];

  // R9: an erased store presents the idle term pattern
  a_r9_idle_terms: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (reset_term && (oe_term == '1) && (data_term == '0) && (en_term == '0)))
    else $error("R9 idle term pattern wrong");
endmodule

// File: tb/pla_array_tb.sv
module pla_array_tb;
  localparam int unsigned DW = 78;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [38:0]   sig_in;
  logic          cfg_we, cfg_re, cfg_erase;
  logic [6:0]    cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [DW-1:0] cfg_rdata;
  logic [17:0]   data_term, en_term;
  logic          reset_term;
  logic [9:0]    oe_term;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string         tag;
    logic [DW-1:0] val;
  } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  pla_array u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (sig_in),
    .cfg_we    (cfg_we),
    .cfg_re    (cfg_re),
    .cfg_erase (cfg_erase),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .data_term (data_term),
    .en_term   (en_term),
    .reset_term(reset_term),
    .oe_term   (oe_term)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: a read seen at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= cfg_re;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected read actual=%h expected=none", cfg_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, cfg_rdata, e.val);
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [DW-1:0] expv, input string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.val = expv;
    exp_q.push_back(e);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic drive(input logic [38:0] v);
    @(negedge clk);
    sig_in = v;
    #1;
  endtask

  task automatic terms(string tag, logic [17:0] d, logic [17:0] e, logic r, logic [9:0] o);
    chk({tag, " data"},  DW'(data_term),  DW'(d));
    chk({tag, " en"},    DW'(en_term),    DW'(e));
    chk({tag, " reset"}, DW'(reset_term), DW'(r));
    chk({tag, " oe"},    DW'(oe_term),    DW'(o));
  endtask

  localparam logic [71:0] SIGN = 72'hC3_5A_A5_0F_F0_12_34_56_78;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sig_in = '0; cfg_we = 1'b0; cfg_re = 1'b0;
    cfg_erase = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 / R2: reset state
    drive('0);
    terms("R9 reset", 18'h0, 18'h0, 1'b1, 10'h3ff);
    chk("R9 rdata", cfg_rdata, '0);
    rd(7'd0, '0, "R9 row0 empty");

    // R1 / R3 / R4 / R10: program planes
    wr(7'd0, DW'(78'h9));              // sig0 true AND sig1 complement
    wr(7'd75, DW'(64'h1));             // sum0 <- pt0
    wr(7'd93, DW'(64'h1));             // sum18 (enable cell 0) <- pt0
    wr(7'd80, DW'(64'h2));             // sum5 <- pt1 (empty row, R2)
    wr(7'd64, DW'(1) << 76);           // reset term <- sig38 true
    wr(7'd65, DW'(78'h20));            // oe0 <- sig2 complement

    drive('0);
    terms("R1 R4 pattern0", 18'h20, 18'h0, 1'b0, 10'h3ff);
    drive(39'h1);
    terms("R1 R3 R10 pattern1", 18'h21, 18'h1, 1'b0, 10'h3ff);
    drive(39'h3);
    terms("R1 pattern3", 18'h20, 18'h0, 1'b0, 10'h3ff);
    drive((39'h1 << 38) | 39'h5);
    terms("R4 pattern_clk", 18'h21, 18'h1, 1'b1, 10'h3fe);

    // R5: readback
    rd(7'd0,  DW'(78'h9), "R5 and row0");
    rd(7'd64, DW'(1) << 76, "R5 and row64");
    rd(7'd80, DW'(64'h2), "R5 or row5");
    wr(7'd111, DW'(SIGN));
    rd(7'd111, DW'(SIGN), "R5 signature");
    rd(7'd112, '0, "R5 lock clear");
    rd(7'd120, '0, "R5 unmapped");

    // R6: protection
    wr(7'd112, DW'(1));
    rd(7'd112, DW'(1), "R6 lock set");
    rd(7'd0,  '0, "R6 and row0 hidden");
    rd(7'd65, '0, "R6 oe row hidden");
    rd(7'd75, DW'(64'h1), "R6 or row visible");
    rd(7'd111, DW'(SIGN), "R6 signature visible");

    // R7: writes ignored while protected
    wr(7'd75, '0);
    wr(7'd0, '0);
    wr(7'd111, '0);
    drive(39'h1);
    terms("R7 locked terms", 18'h21, 18'h1, 1'b0, 10'h3ff);
    rd(7'd75, DW'(64'h1), "R7 or row kept");
    rd(7'd111, DW'(SIGN), "R7 signature kept");

    // R8: bulk erase, with a write in the same cycle
    @(negedge clk);
    cfg_erase = 1'b1; cfg_we = 1'b1; cfg_addr = 7'd80; cfg_wdata = DW'(64'h2);
    @(negedge clk);
    cfg_erase = 1'b0; cfg_we = 1'b0;
    drive(39'h1);
    terms("R8 erased terms", 18'h0, 18'h0, 1'b1, 10'h3ff);
    rd(7'd112, '0, "R8 lock cleared");
    rd(7'd111, '0, "R8 signature cleared");
    rd(7'd75, '0, "R8 or row cleared");

    // R8 / R10: store writable again after erase
    wr(7'd80, DW'(64'h2));
    drive('0);
    chk("R10 post-erase write", DW'(data_term), DW'(18'h20));
    rd(7'd0, '0, "R8 and row cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule